// File: doc/BRIEF.md
# One-Time-Programmable ROM Mode Decoder with Identifier Bytes

This block is a synthesizable, device-side model of a byte-wide one-time-programmable ROM. Each clock it samples the active-low chip enable and output enable, a flag saying the programming supply is present, and a flag saying the identifier over-voltage is present. From these it decodes the operating mode. Depending on that mode it returns a stored byte, a fixed identifier byte, or nothing. Analog levels are reduced to single-bit flags, and delays are reduced to a fixed clock latency.

Programming can only clear bits. On each falling edge of chip enable in program mode, the addressed word takes the bitwise AND of its old value and the input byte. The only way back to all ones is an explicit erase request, which sweeps the whole array. The block has no tri-state pin. It exports a registered drive-enable, and the data output is forced to zero whenever that drive-enable is low.

The default array is 2048 words, so that elaboration stays small. Setting `ADDR_W` to 15 gives the full 32K x 8 organisation.

Top module: `otprom_device`

## Requirements
- R1: During and right after reset, `drive_en` is 0, `dout` is 0 and `mode` is 0 (standby).
- R2: With `prog_volt`=0, `chip_en_n`=0, `out_en_n`=0 and `sig_hv`=0, the mode is Read (code 1), `drive_en` is 1 and `dout` is the stored word at `addr`. Outputs reflect the inputs after two rising clock edges.
- R3: With `prog_volt`=0, `chip_en_n`=0 and `out_en_n`=1, the mode is Output Disable (code 2) and `drive_en` is 0.
- R4: With `prog_volt`=0 and `chip_en_n`=1, the mode is Standby (code 0) and `drive_en` is 0, whatever the values of `out_en_n` and `sig_hv`.
- R5: With `prog_volt`=1 and `out_en_n`=1, a high-to-low transition of `chip_en_n` (between two consecutive clock samples) is Program (code 3). It stores old word AND `din` exactly once. Holding `chip_en_n` low writes nothing more, even if `din` changes.
- R6: With `prog_volt`=1, `chip_en_n`=1 and `out_en_n`=0, the mode is Verify (code 4) and the stored word is driven.
- R7: With `prog_volt`=1, both enables high, or both enables low, give Program Inhibit (code 5): nothing is driven and nothing is written.
- R8: With `prog_volt`=0, both enables low and `sig_hv`=1, the mode is Signature (code 6). `dout` is 8'h20 when `addr[0]`=0 and 8'h8D when `addr[0]`=1. The other address bits have no effect.
- R9: No program operation turns a stored 0 bit into 1.
- R10: A cycle with `erase`=1 starts a sweep that sets every word to all ones over 2^ADDR_W cycles. During the sweep the mode is Erase (code 7), nothing is driven and program pulses are ignored.
- R11: A chip-enable falling edge with `out_en_n`=1 but `prog_volt`=0 leaves the array unchanged.
- R12: `dout` is 0 whenever `drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (array contents kept) |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| prog_volt | input | 1 | Programming supply present |
| sig_hv | input | 1 | Identifier over-voltage present |
| erase | input | 1 | Request to sweep the array to all ones |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Byte returned (zero when not driving) |
| drive_en | output | 1 | Enable for an external tri-state driver |
| mode | output | 3 | Decoded operating mode code |

## Verification
The hardest case to reach from the ports is a second write during one long chip-enable low phase. It is invisible unless the input byte changes while the enable is still low and the word is read back afterwards. The stimulus therefore holds chip enable low over two steps, clearing `din` to zero in the second step. A later read must still show only the first AND. Random steps over a small pool of addresses, with all four control flags random, also produce repeated ANDs into the same word. These steps mix supply-absent falling edges and inhibit combinations with real writes, and the bench compares each one against its own array model.

// File: rtl/otprom_pkg.sv
package otprom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY   = 3'd0,
    MODE_READ      = 3'd1,
    MODE_OUTDIS    = 3'd2,
    MODE_PROGRAM   = 3'd3,
    MODE_VERIFY    = 3'd4,
    MODE_INHIBIT   = 3'd5,
    MODE_SIGNATURE = 3'd6,
    MODE_ERASE     = 3'd7
  } rom_mode_e;

  function automatic logic mode_drives(rom_mode_e m);
    return (m == MODE_READ) || (m == MODE_VERIFY) || (m == MODE_SIGNATURE);
  endfunction

endpackage

// File: rtl/otprom_mode_decode.sv
module otprom_mode_decode
  import otprom_pkg::*;
(
  input  logic      chip_en_n,
  input  logic      out_en_n,
  input  logic      prog_volt,
  input  logic      sig_hv,
  input  logic      erase_busy,
  output rom_mode_e mode
);

  always_comb begin
    if (erase_busy) begin
      mode = MODE_ERASE;
    end else if (prog_volt) begin
      unique case ({chip_en_n, out_en_n})
        2'b01:   mode = MODE_PROGRAM;
        2'b10:   mode = MODE_VERIFY;
        default: mode = MODE_INHIBIT;
      endcase
    end else if (chip_en_n) begin
      mode = MODE_STANDBY;
    end else if (out_en_n) begin
      mode = MODE_OUTDIS;
    end else begin
      mode = sig_hv ? MODE_SIGNATURE : MODE_READ;
    end
  end

endmodule

// File: rtl/otprom_sig_src.sv
module otprom_sig_src #(
  parameter int          DATA_W     = 8,
  parameter logic [DATA_W-1:0] CODE_LO = 8'h20,
  parameter logic [DATA_W-1:0] CODE_HI = 8'h8D
) (
  input  logic              sel,
  output logic [DATA_W-1:0] code
);

  assign code = sel ? CODE_HI : CODE_LO;

endmodule

// File: rtl/otprom_array.sv
module otprom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_mask,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              busy_q;
  logic [ADDR_W-1:0] sweep_cnt;

  // Single write port: the erase sweep has priority over a program write.
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
    if (busy_q) begin
      mem[sweep_cnt] <= '1;
    end else if (wr_en) begin
      mem[wr_addr] <= rd_q & wr_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sweep_cnt <= '0;
    end else if (busy_q) begin
      if (sweep_cnt == LAST) begin
        busy_q    <= 1'b0;
        sweep_cnt <= '0;
      end else begin
        sweep_cnt <= sweep_cnt + 1'b1;
      end
    end else if (erase_req) begin
      busy_q    <= 1'b1;
      sweep_cnt <= '0;
    end
  end

  assign rd_data = rd_q;
  assign busy    = busy_q;

  // R10
  sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (sweep_cnt == '0));

  // R10
  no_write_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy_q);

endmodule

// File: rtl/otprom_device.sv
module otprom_device
  import otprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SIG_MAKER  = 8'h20,
  parameter logic [DATA_W-1:0] SIG_DEVICE = 8'h8D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              prog_volt,
  input  logic              sig_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              drive_en,
  output logic [2:0]        mode
);

  rom_mode_e         mode_cmb;
  rom_mode_e         mode_s1;
  rom_mode_e         mode_q;
  logic              busy;
  logic              ce_prev_q;
  logic              prog_fire_s1;
  logic              a0_s1;
  logic [ADDR_W-1:0] addr_s1;
  logic [DATA_W-1:0] din_s1;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] sig_code;
  logic [DATA_W-1:0] dout_q;
  logic              drive_q;

  otprom_mode_decode u_decode (
    .chip_en_n  (chip_en_n),
    .out_en_n   (out_en_n),
    .prog_volt  (prog_volt),
    .sig_hv     (sig_hv),
    .erase_busy (busy || erase),
    .mode       (mode_cmb)
  );

  // Stage 1: capture decoded mode, address and the program strobe edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_s1      <= MODE_STANDBY;
      ce_prev_q    <= 1'b0;
      prog_fire_s1 <= 1'b0;
      a0_s1        <= 1'b0;
      addr_s1      <= '0;
      din_s1       <= '0;
    end else begin
      mode_s1      <= mode_cmb;
      ce_prev_q    <= chip_en_n;
      prog_fire_s1 <= (mode_cmb == MODE_PROGRAM) && ce_prev_q;
      a0_s1        <= addr[0];
      addr_s1      <= addr;
      din_s1       <= din;
    end
  end

  otprom_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk       (clk),
    .rst       (rst),
    .erase_req (erase),
    .rd_addr   (addr),
    .wr_en     (prog_fire_s1),
    .wr_addr   (addr_s1),
    .wr_mask   (din_s1),
    .rd_data   (rdata),
    .busy      (busy)
  );

  otprom_sig_src #(
    .DATA_W  (DATA_W),
    .CODE_LO (SIG_MAKER),
    .CODE_HI (SIG_DEVICE)
  ) u_sig (
    .sel  (a0_s1),
    .code (sig_code)
  );

  // Stage 2: registered output mux.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_STANDBY;
      drive_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      mode_q  <= mode_s1;
      drive_q <= mode_drives(mode_s1);
      unique case (mode_s1)
        MODE_READ, MODE_VERIFY: dout_q <= rdata;
        MODE_SIGNATURE:         dout_q <= sig_code;
        default:                dout_q <= '0;
      endcase
    end
  end

  assign dout     = dout_q;
  assign drive_en = drive_q;
  assign mode     = mode_q;

  // R12
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_q |-> (dout_q == '0));

  // R8
  sig_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SIGNATURE) |-> ((dout_q == SIG_MAKER) || (dout_q == SIG_DEVICE)));

  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STANDBY) |-> !drive_q);

  // R11
  prog_needs_vpp_chk: assert property (@(posedge clk) disable iff (rst)
    prog_fire_s1 |-> ($past(prog_volt) && $past(out_en_n)));

endmodule

// File: tb/otprom_device_tb_top.sv
`timescale 1ns/1ps
module otprom_device_tb_top;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              chip_en_n, out_en_n, prog_volt, sig_hv, erase;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic              drive_en;
  logic [2:0]        mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic prev_ce;
  logic [DATA_W-1:0] model [DEPTH];

  always #10 clk = ~clk;

  otprom_device #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .prog_volt(prog_volt), .sig_hv(sig_hv), .erase(erase), .addr(addr),
    .din(din), .dout(dout), .drive_en(drive_en), .mode(mode)
  );

  function automatic logic [2:0] exp_mode(logic ce, logic oe, logic vp, logic hv);
    if (vp) begin
      if (ce) return oe ? 3'd5 : 3'd4;
      else    return oe ? 3'd3 : 3'd5;
    end
    if (ce) return 3'd0;
    if (oe) return 3'd2;
    return hv ? 3'd6 : 3'd1;
  endfunction

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] em, logic ed, logic [DATA_W-1:0] eq);
    checks++;
    if (mode !== em || drive_en !== ed || dout !== eq) begin
      errors++;
      $display("FAIL %s: mode=%0d drive=%0b dout=%h expected mode=%0d drive=%0b dout=%h",
               tag, mode, drive_en, dout, em, ed, eq);
    end
  endtask

  // One step: drive at negedge, two rising edges, sample at the next negedge.
  task automatic step(logic ce, logic oe, logic vp, logic hv,
                      logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string tag);
    logic [2:0]        em;
    logic              ed;
    logic [DATA_W-1:0] eq;
    chip_en_n = ce; out_en_n = oe; prog_volt = vp; sig_hv = hv; addr = a; din = d;
    em = exp_mode(ce, oe, vp, hv);
    ed = (em == 3'd1) || (em == 3'd4) || (em == 3'd6);
    if (em == 3'd1 || em == 3'd4) eq = model[a];
    else if (em == 3'd6)          eq = a[0] ? 8'h8D : 8'h20;
    else                          eq = 8'h00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check((tag == "") ? tag_of(em) : tag, em, ed, eq);
    if (em == 3'd3 && prev_ce) model[a] = model[a] & d;
    prev_ce = ce;
  endtask

  task automatic do_erase();
    erase = 1'b1; chip_en_n = 1'b1; prog_volt = 1'b0;
    @(posedge clk); @(negedge clk);
    erase = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10", 3'd7, 1'b0, 8'h00);
    // R10: a program pulse during the sweep must be ignored
    prog_volt = 1'b1; out_en_n = 1'b1; chip_en_n = 1'b0; addr = 11'd9; din = 8'h00;
    @(posedge clk); @(negedge clk);
    chip_en_n = 1'b1; prog_volt = 1'b0;
    repeat (DEPTH + 4) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    prev_ce = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    void'($urandom(32'd20250));
    rst = 1'b1; chip_en_n = 1'b1; out_en_n = 1'b1; prog_volt = 1'b0;
    sig_hv = 1'b0; erase = 1'b0; addr = '0; din = '0; prev_ce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 3'd0, 1'b0, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 3'd0, 1'b0, 8'h00);

    do_erase();
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 1'b0, ADDR_W'($urandom), 8'h00, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b0, 11'd9, 8'h00, "R10");

    // R5: one write per falling edge; din changes while held low
    step(1'b1, 1'b1, 1'b1, 1'b0, 11'd100, 8'h3C, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 11'd100, 8'h3C, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, 11'd100, 8'h00, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 11'd100, 8'h00, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, 11'd100, 8'h00, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0, 11'd100, 8'h00, "R5");

    // R9: bits never return to 1
    step(1'b0, 1'b1, 1'b1, 1'b0, 11'd5, 8'h0F, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 11'd5, 8'hF0, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 11'd5, 8'hF0, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 11'd5, 8'hFF, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 11'd5, 8'hFF, "R9");
    step(1'b1, 1'b0, 1'b1, 1'b0, 11'd5, 8'h00, "R9");

    // R11: falling edge without programming supply
    step(1'b1, 1'b1, 1'b0, 1'b0, 11'd200, 8'h00, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b0, 11'd200, 8'h00, "R11");
    step(1'b0, 1'b0, 1'b0, 1'b0, 11'd200, 8'h00, "R11");

    // R7: both enables low with supply present
    step(1'b0, 1'b0, 1'b1, 1'b0, 11'd300, 8'h00, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 11'd300, 8'h00, "R7");

    // R8 and R4 and R3 and R12
    for (int i = 0; i < 6; i++) begin
      a = ADDR_W'($urandom);
      step(1'b0, 1'b0, 1'b0, 1'b1, a, 8'h00, "R8");
      step(1'b1, i[0], 1'b0, 1'b1, a, 8'h00, "R4");
      step(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00, "R12");
    end

    // Random mixed steps on a small address pool
    for (int i = 0; i < 400; i++) begin
      a = ADDR_W'(11'd1024 + ($urandom % 16));
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           a, DATA_W'($urandom), "");
    end
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b0, 1'b0, ADDR_W'(1024 + i), 8'h00, "R9");

    // R10: erase again restores all ones
    do_erase();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1, 1'b0, ADDR_W'(1024 + i), 8'h00, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule